// File: doc/BRIEF.md
# Paged Packet-Memory Ring Address Generator

This block produces byte addresses into a local packet memory that is cut into pages of 256 bytes. The memory holds two circular buffers that sit next to each other: a transmit ring running from a programmable low page up to one page below a shared boundary page, and a receive ring running from that boundary page up to a programmable high page. Each ring wraps at page granularity, so a walk that leaves its last page re-enters its first page.

Each ring has a walk port with three strobes: begin a packet, step one byte, close the packet. Every packet begins on a fresh page. The first four bytes of that page are kept free for a descriptor, and payload addressing starts right after them. A packet may run on across several pages of its ring. When it closes, the rest of its last page is left unused and the next packet opens on the following page. On close, the block reports the packet's first page and how many pages it took, so that a driver can move its own pointers on.

A small write port loads the three page pointers. A write is accepted only while both rings are idle, and it rewinds both rings to their first pages. A combinational flag reports a pointer set that does not describe two valid rings.

Top module: `pkt_ring_addr_gen`

## Requirements
- R1: After reset both rings are idle, no done pulse is present, the configuration-error flag is low, and the pointers hold transmit low page 0x00, boundary page 0x40 and receive high page 0xFF. The first packets therefore start at byte address 0x0004 (transmit) and 0x4004 (receive).
- R2: The byte address output equals page*256 + offset. A started packet is placed at offset 4 of its first page, because bytes 0..3 are kept for the descriptor. The packet-page output shows that first page while the packet is open.
- R3: A step strobe on a busy ring raises the offset by one. A step taken from offset 255 moves to offset 0 of the next page of the ring.
- R4: On the transmit ring, the page after boundary-1 is the transmit low page.
- R5: On the receive ring, the page after the receive high page is the boundary page.
- R6: After a packet closes, the next packet on that ring starts on the ring page that follows the last page holding payload, wrapping as in R4/R5. The unused tail of that page is skipped.
- R7: If the final step left the walk at offset 0 of a page that holds no byte, and the packet spans more than one page, that empty page is not counted, and the next packet starts on it.
- R8: One cycle after a close strobe, the ring's done output pulses high for one cycle and busy is low. The done-page output shows the packet's first page and the done-count output shows the number of pages the packet used.
- R9: A pointer write (select 0 = transmit low, 1 = boundary, 2 = receive high, 3 = no target) takes effect only when both rings are idle, and a write made while either ring is busy changes nothing. An accepted write with select 0..2 rewinds the transmit ring to its low page and the receive ring to the boundary page, and this applies to a start strobe in the same cycle too.
- R10: The configuration-error flag is high exactly when transmit low >= boundary or receive high < boundary.
- R11: A start strobe on a busy ring, and step or close strobes on an idle ring, have no effect. A close and a step in the same cycle close the packet, and the step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_sel | input | 2 | Pointer select: 0 transmit low, 1 boundary, 2 receive high, 3 none |
| cfg_wdata | input | 8 | Page value to write |
| cfg_err | output | 1 | Pointer set is inconsistent |
| tx_start | input | 1 | Begin a transmit packet |
| tx_adv | input | 1 | Step one transmit byte |
| tx_end | input | 1 | Close the transmit packet |
| tx_busy | output | 1 | Transmit packet open |
| tx_addr | output | 16 | Current transmit byte address |
| tx_pkt_page | output | 8 | First page of the open transmit packet |
| tx_done | output | 1 | Transmit packet closed (one-cycle pulse) |
| tx_done_page | output | 8 | First page of the closed transmit packet |
| tx_done_pages | output | 9 | Pages used by the closed transmit packet |
| rx_start | input | 1 | Begin a receive packet |
| rx_adv | input | 1 | Step one receive byte |
| rx_end | input | 1 | Close the receive packet |
| rx_busy | output | 1 | Receive packet open |
| rx_addr | output | 16 | Current receive byte address |
| rx_pkt_page | output | 8 | First page of the open receive packet |
| rx_done | output | 1 | Receive packet closed (one-cycle pulse) |
| rx_done_pages | output | 9 | Pages used by the closed receive packet |
| rx_done_page | output | 8 | First page of the closed receive packet |

## Verification
The case hardest to reach from the ports is a ring wrap that falls exactly on a page edge and is followed at once by a close. In that case the empty page must be left out of the count and reused for the next packet. The stimulus shrinks the rings to two pages each through the pointer port and then steps an exact byte count (252 + 256) so that the walk lands on offset 0 of the ring's first page just before the close. A long random phase then mixes starts, steps, closes and pointer writes. Some of those writes arrive while a ring is busy, and some give inconsistent pointer sets. A behavioural model tracks every output in every cycle.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;
  localparam int PAGE_W = 8;
  localparam int OFS_W  = 8;
  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int CNT_W  = PAGE_W + 1;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {
    SEL_TX_LOW  = 2'd0,
    SEL_BOUND   = 2'd1,
    SEL_RX_HIGH = 2'd2,
    SEL_NONE    = 2'd3
  } ptr_sel_e;

  // next page inside a ring [lo..hi], wrapping at hi
  function automatic page_t page_step(page_t p, page_t lo, page_t hi);
    return (p == hi) ? lo : page_t'(p + page_t'(1));
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
  import pkt_ring_pkg::*;
#(
  parameter page_t TXLO_RST = 8'h00,
  parameter page_t BP_RST   = 8'h40,
  parameter page_t RXHI_RST = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [PAGE_W-1:0] wdata,
  input  logic             rings_idle,
  output page_t            txlo,
  output page_t            bp,
  output page_t            rxhi,
  output page_t            txlo_nxt,
  output page_t            bp_nxt,
  output logic             rearm,
  output logic             cfg_err
);
  page_t txlo_q, bp_q, rxhi_q;
  page_t txlo_d, bp_d, rxhi_d;
  logic  accept;
  ptr_sel_e sel_e;

  assign sel_e  = ptr_sel_e'(sel);
  assign accept = we && rings_idle && (sel_e != SEL_NONE);

  always_comb begin
    txlo_d = txlo_q;
    bp_d   = bp_q;
    rxhi_d = rxhi_q;
    if (accept) begin
      unique case (sel_e)
        SEL_TX_LOW:  txlo_d = wdata;
        SEL_BOUND:   bp_d   = wdata;
        SEL_RX_HIGH: rxhi_d = wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txlo_q <= TXLO_RST;
      bp_q   <= BP_RST;
      rxhi_q <= RXHI_RST;
    end else if (accept) begin
      txlo_q <= txlo_d;
      bp_q   <= bp_d;
      rxhi_q <= rxhi_d;
    end
  end

  assign txlo     = txlo_q;
  assign bp       = bp_q;
  assign rxhi     = rxhi_q;
  assign txlo_nxt = txlo_d;
  assign bp_nxt   = bp_d;
  assign rearm    = accept;
  assign cfg_err  = (txlo_q >= bp_q) || (rxhi_q < bp_q);

  // writes during an open packet must leave every pointer untouched
  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !rings_idle) |=> ($stable(txlo_q) && $stable(bp_q) && $stable(rxhi_q)));
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import pkt_ring_pkg::*;
#(
  parameter int    DESC_BYTES = 4,
  parameter page_t RST_PAGE   = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  page_t lo,
  input  page_t hi,
  input  logic  rearm,
  input  page_t rearm_lo,
  input  logic  start,
  input  logic  adv,
  input  logic  fin,
  output logic  busy,
  output logic [ADDR_W-1:0] addr,
  output page_t pkt_page,
  output logic  done,
  output page_t done_page,
  output cnt_t  done_cnt
);
  localparam ofs_t DESC_OFS = ofs_t'(DESC_BYTES);
  localparam ofs_t OFS_LAST = '1;
  localparam cnt_t CNT_ONE  = cnt_t'(1);

  logic  busy_q, busy_d;
  page_t page_q, page_d;
  ofs_t  ofs_q, ofs_d;
  page_t first_q, first_d;
  cnt_t  npg_q, npg_d;
  page_t next_q, next_d;
  logic  done_q, done_d;
  page_t dpage_q, dpage_d;
  cnt_t  dcnt_q, dcnt_d;
  page_t base;
  logic  tail_empty;

  assign base       = rearm ? rearm_lo : next_q;
  assign tail_empty = (ofs_q == '0) && (npg_q > CNT_ONE);

  always_comb begin
    busy_d  = busy_q;
    page_d  = page_q;
    ofs_d   = ofs_q;
    first_d = first_q;
    npg_d   = npg_q;
    next_d  = next_q;
    done_d  = 1'b0;
    dpage_d = dpage_q;
    dcnt_d  = dcnt_q;
    if (!busy_q) begin
      next_d = base;
      if (start) begin
        busy_d  = 1'b1;
        page_d  = base;
        ofs_d   = DESC_OFS;
        first_d = base;
        npg_d   = CNT_ONE;
      end
    end else if (fin) begin
      busy_d  = 1'b0;
      done_d  = 1'b1;
      dpage_d = first_q;
      if (tail_empty) begin
        dcnt_d = npg_q - CNT_ONE;
        next_d = page_q;
      end else begin
        dcnt_d = npg_q;
        next_d = page_step(page_q, lo, hi);
      end
    end else if (adv) begin
      if (ofs_q == OFS_LAST) begin
        ofs_d  = '0;
        page_d = page_step(page_q, lo, hi);
        npg_d  = npg_q + CNT_ONE;
      end else begin
        ofs_d = ofs_q + ofs_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      page_q  <= '0;
      ofs_q   <= '0;
      first_q <= '0;
      npg_q   <= '0;
      next_q  <= RST_PAGE;
      done_q  <= 1'b0;
      dpage_q <= '0;
      dcnt_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      page_q  <= page_d;
      ofs_q   <= ofs_d;
      first_q <= first_d;
      npg_q   <= npg_d;
      next_q  <= next_d;
      done_q  <= done_d;
      dpage_q <= dpage_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign busy      = busy_q;
  assign addr      = {page_q, ofs_q};
  assign pkt_page  = first_q;
  assign done      = done_q;
  assign done_page = dpage_q;
  assign done_cnt  = dcnt_q;

  // a fresh packet leaves the descriptor slot free
  assert_desc_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (ofs_q == DESC_OFS && page_q == first_q));

  // a lone step inside a page moves the offset by exactly one
  assert_ofs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && adv && !fin && ofs_q != OFS_LAST) |=> (ofs_q == $past(ofs_q) + ofs_t'(1)));

  // a close yields one nonzero report and an idle ring
  assert_done_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && dcnt_q != '0));

  // start strobes on an open packet leave its first page alone
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> $stable(first_q));
endmodule

// File: rtl/pkt_ring_addr_gen.sv
module pkt_ring_addr_gen
  import pkt_ring_pkg::*;
#(
  parameter int    DESC_BYTES = 4,
  parameter page_t TXLO_RST   = 8'h00,
  parameter page_t BP_RST     = 8'h40,
  parameter page_t RXHI_RST   = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [PAGE_W-1:0]  cfg_wdata,
  output logic               cfg_err,
  input  logic               tx_start,
  input  logic               tx_adv,
  input  logic               tx_end,
  output logic               tx_busy,
  output logic [ADDR_W-1:0]  tx_addr,
  output logic [PAGE_W-1:0]  tx_pkt_page,
  output logic               tx_done,
  output logic [PAGE_W-1:0]  tx_done_page,
  output logic [CNT_W-1:0]   tx_done_pages,
  input  logic               rx_start,
  input  logic               rx_adv,
  input  logic               rx_end,
  output logic               rx_busy,
  output logic [ADDR_W-1:0]  rx_addr,
  output logic [PAGE_W-1:0]  rx_pkt_page,
  output logic               rx_done,
  output logic [CNT_W-1:0]   rx_done_pages,
  output logic [PAGE_W-1:0]  rx_done_page
);
  localparam int NRING = 2;

  logic  rst_i;
  page_t txlo, bp, rxhi, txlo_nxt, bp_nxt;
  logic  rearm;

  page_t            r_lo [NRING];
  page_t            r_hi [NRING];
  page_t            r_rlo[NRING];
  logic [NRING-1:0] r_start, r_adv, r_fin, r_busy, r_done;
  logic [ADDR_W-1:0] r_addr[NRING];
  page_t            r_ppg[NRING];
  page_t            r_dpg[NRING];
  cnt_t             r_dcnt[NRING];

  rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_i)
  );

  ring_ptr_regs #(
    .TXLO_RST(TXLO_RST),
    .BP_RST  (BP_RST),
    .RXHI_RST(RXHI_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_i),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .rings_idle(~|r_busy),
    .txlo      (txlo),
    .bp        (bp),
    .rxhi      (rxhi),
    .txlo_nxt  (txlo_nxt),
    .bp_nxt    (bp_nxt),
    .rearm     (rearm),
    .cfg_err   (cfg_err)
  );

  // ring 0 transmits in [txlo .. bp-1], ring 1 receives in [bp .. rxhi]
  assign r_lo[0]  = txlo;
  assign r_hi[0]  = bp - page_t'(1);
  assign r_rlo[0] = txlo_nxt;
  assign r_lo[1]  = bp;
  assign r_hi[1]  = rxhi;
  assign r_rlo[1] = bp_nxt;

  assign r_start = {rx_start, tx_start};
  assign r_adv   = {rx_adv,   tx_adv};
  assign r_fin   = {rx_end,   tx_end};

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ring_walker #(
      .DESC_BYTES(DESC_BYTES),
      .RST_PAGE  ((g == 0) ? TXLO_RST : BP_RST)
    ) u_walk (
      .clk      (clk),
      .rst_n    (rst_i),
      .lo       (r_lo[g]),
      .hi       (r_hi[g]),
      .rearm    (rearm),
      .rearm_lo (r_rlo[g]),
      .start    (r_start[g]),
      .adv      (r_adv[g]),
      .fin      (r_fin[g]),
      .busy     (r_busy[g]),
      .addr     (r_addr[g]),
      .pkt_page (r_ppg[g]),
      .done     (r_done[g]),
      .done_page(r_dpg[g]),
      .done_cnt (r_dcnt[g])
    );
  end

  assign tx_busy       = r_busy[0];
  assign tx_addr       = r_addr[0];
  assign tx_pkt_page   = r_ppg[0];
  assign tx_done       = r_done[0];
  assign tx_done_page  = r_dpg[0];
  assign tx_done_pages = r_dcnt[0];
  assign rx_busy       = r_busy[1];
  assign rx_addr       = r_addr[1];
  assign rx_pkt_page   = r_ppg[1];
  assign rx_done       = r_done[1];
  assign rx_done_page  = r_dpg[1];
  assign rx_done_pages = r_dcnt[1];

  // an open transmit walk never leaves [txlo .. bp-1] on a sane pointer set
  assert_tx_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_busy && !cfg_err) |-> (tx_addr[ADDR_W-1:OFS_W] >= txlo && tx_addr[ADDR_W-1:OFS_W] < bp));

  // an open receive walk never leaves [bp .. rxhi] on a sane pointer set
  assert_rx_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_busy && !cfg_err) |-> (rx_addr[ADDR_W-1:OFS_W] >= bp && rx_addr[ADDR_W-1:OFS_W] <= rxhi));
endmodule

// File: tb/test_pkt_ring_addr_gen.sv
`timescale 1ns/1ps
module test_pkt_ring_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic cfg_err;
  logic [1:0] st = 2'b00, ad = 2'b00, en = 2'b00;
  logic tx_busy, rx_busy, tx_done, rx_done;
  logic [15:0] tx_addr, rx_addr;
  logic [7:0] tx_pkt_page, rx_pkt_page, tx_done_page, rx_done_page;
  logic [8:0] tx_done_pages, rx_done_pages;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pkt_ring_addr_gen i_pkt_ring_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
    .tx_start(st[0]), .tx_adv(ad[0]), .tx_end(en[0]),
    .tx_busy(tx_busy), .tx_addr(tx_addr), .tx_pkt_page(tx_pkt_page),
    .tx_done(tx_done), .tx_done_page(tx_done_page), .tx_done_pages(tx_done_pages),
    .rx_start(st[1]), .rx_adv(ad[1]), .rx_end(en[1]),
    .rx_busy(rx_busy), .rx_addr(rx_addr), .rx_pkt_page(rx_pkt_page),
    .rx_done(rx_done), .rx_done_pages(rx_done_pages), .rx_done_page(rx_done_page)
  );

  // behavioural reference state
  int m_busy[2], m_page[2], m_ofs[2], m_first[2], m_npg[2], m_nxt[2];
  int m_done[2], m_dpage[2], m_dcnt[2];
  int m_txlo, m_bp, m_rxhi;
  bit m_s1, m_s2;

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin
      m_busy[r] = 0; m_page[r] = 0; m_ofs[r] = 0; m_first[r] = 0; m_npg[r] = 0;
      m_done[r] = 0; m_dpage[r] = 0; m_dcnt[r] = 0;
    end
    m_txlo = 8'h00; m_bp = 8'h40; m_rxhi = 8'hFF;
    m_nxt[0] = 8'h00; m_nxt[1] = 8'h40;
  endtask

  task automatic model_step();
    bit old2, acc;
    int n_txlo, n_bp, n_rxhi, lo, hi, base;
    int lo_new[2];
    old2 = m_s2;
    m_s2 = m_s1;
    m_s1 = rst_n;
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    if (!old2 || !rst_n) begin
      model_reset();
      return;
    end
    acc = cfg_we && !m_busy[0] && !m_busy[1] && cfg_sel != 2'd3;
    n_txlo = m_txlo; n_bp = m_bp; n_rxhi = m_rxhi;
    if (acc) begin
      if (cfg_sel == 2'd0) n_txlo = cfg_wdata;
      if (cfg_sel == 2'd1) n_bp = cfg_wdata;
      if (cfg_sel == 2'd2) n_rxhi = cfg_wdata;
    end
    lo_new[0] = n_txlo; lo_new[1] = n_bp;
    for (int r = 0; r < 2; r++) begin
      lo = (r == 0) ? m_txlo : m_bp;
      hi = (r == 0) ? ((m_bp + 255) % 256) : m_rxhi;
      m_done[r] = 0;
      base = acc ? lo_new[r] : m_nxt[r];
      if (!m_busy[r]) begin
        m_nxt[r] = base;
        if (st[r]) begin
          m_busy[r] = 1; m_page[r] = base; m_ofs[r] = 4; m_first[r] = base; m_npg[r] = 1;
        end
      end else if (en[r]) begin
        m_busy[r] = 0; m_done[r] = 1; m_dpage[r] = m_first[r];
        if (m_ofs[r] == 0 && m_npg[r] > 1) begin
          m_dcnt[r] = m_npg[r] - 1; m_nxt[r] = m_page[r];
        end else begin
          m_dcnt[r] = m_npg[r];
          m_nxt[r] = (m_page[r] == hi) ? lo : (m_page[r] + 1) % 256;
        end
      end else if (ad[r]) begin
        if (m_ofs[r] == 255) begin
          m_ofs[r] = 0;
          m_page[r] = (m_page[r] == hi) ? lo : (m_page[r] + 1) % 256;
          m_npg[r] = (m_npg[r] + 1) % 512;
        end else m_ofs[r] = m_ofs[r] + 1;
      end
    end
    m_txlo = n_txlo; m_bp = n_bp; m_rxhi = n_rxhi;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int err;
    err = (m_txlo >= m_bp) || (m_rxhi < m_bp);
    chk("R10 cfg_err", cfg_err, err);
    chk("R11 tx_busy", tx_busy, m_busy[0]);
    chk("R11 rx_busy", rx_busy, m_busy[1]);
    chk("R2 tx_addr", tx_addr, m_page[0] * 256 + m_ofs[0]);
    chk("R2 rx_addr", rx_addr, m_page[1] * 256 + m_ofs[1]);
    chk("R2 tx_pkt_page", tx_pkt_page, m_first[0]);
    chk("R2 rx_pkt_page", rx_pkt_page, m_first[1]);
    chk("R8 tx_done", tx_done, m_done[0]);
    chk("R8 rx_done", rx_done, m_done[1]);
    chk("R8 tx_done_page", tx_done_page, m_dpage[0]);
    chk("R8 rx_done_page", rx_done_page, m_dpage[1]);
    chk("R8 tx_done_pages", tx_done_pages, m_dcnt[0]);
    chk("R8 rx_done_pages", rx_done_pages, m_dcnt[1]);
  endtask

  // one clock: model and DUT take the same inputs, compare just after the edge
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic drive(logic [1:0] s, logic [1:0] a, logic [1:0] e);
    st = s; ad = a; en = e;
    tick();
    st = 2'b00; ad = 2'b00; en = 2'b00;
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic steps(int ring, int n);
    for (int i = 0; i < n; i++) drive(2'b00, (ring == 0) ? 2'b01 : 2'b10, 2'b00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    m_s1 = 0; m_s2 = 0;
    #1;
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R1 reset state and default pointers
    chk("R1 busy", {tx_busy, rx_busy}, 0);
    chk("R1 done", {tx_done, rx_done}, 0);
    chk("R1 cfg_err", cfg_err, 0);
    drive(2'b11, 2'b00, 2'b00);
    chk("R1 tx first addr", tx_addr, 16'h0004);
    chk("R1 rx first addr", rx_addr, 16'h4004);
    drive(2'b00, 2'b00, 2'b11);
    chk("R8 tx done pulse", tx_done, 1);
    chk("R8 tx one page", tx_done_pages, 1);
    tick();
    chk("R8 done single cycle", tx_done, 0);

    // R9 shrink rings: tx pages 2..3, rx pages 4..5
    cfg_write(2'd1, 8'h04);
    cfg_write(2'd0, 8'h02);
    cfg_write(2'd2, 8'h05);
    chk("R10 sane set", cfg_err, 0);
    drive(2'b01, 2'b00, 2'b00);
    chk("R9 rewind to tx low", tx_addr, 16'h0204);
    chk("R2 pkt page", tx_pkt_page, 8'h02);
    steps(0, 252);
    chk("R3 page step", tx_addr, 16'h0300);
    steps(0, 256);
    chk("R4 tx wrap", tx_addr, 16'h0200);
    steps(0, 92);
    chk("R3 offset", tx_addr, 16'h025C);
    drive(2'b00, 2'b00, 2'b01);
    chk("R8 done page", tx_done_page, 8'h02);
    chk("R8 page count", tx_done_pages, 3);
    chk("R8 idle", tx_busy, 0);
    drive(2'b01, 2'b00, 2'b00);
    chk("R6 fragment skipped", tx_addr, 16'h0304);
    drive(2'b00, 2'b00, 2'b01);
    drive(2'b01, 2'b00, 2'b00);
    chk("R6 next start wraps", tx_addr, 16'h0204);
    cfg_write(2'd1, 8'h01);
    chk("R9 write ignored when busy", cfg_err, 0);
    drive(2'b00, 2'b00, 2'b01);

    // receive ring wrap and empty tail page
    drive(2'b10, 2'b00, 2'b00);
    chk("R9 rewind to boundary", rx_addr, 16'h0404);
    steps(1, 252);
    chk("R3 rx page step", rx_addr, 16'h0500);
    steps(1, 256);
    chk("R5 rx wrap", rx_addr, 16'h0400);
    drive(2'b00, 2'b00, 2'b10);
    chk("R7 empty page dropped", rx_done_pages, 2);
    chk("R8 rx done page", rx_done_page, 8'h04);
    drive(2'b10, 2'b00, 2'b00);
    chk("R7 empty page reused", rx_addr, 16'h0404);

    // R11 ignored strobes
    steps(1, 3);
    drive(2'b10, 2'b00, 2'b00);
    chk("R11 start while busy", rx_addr, 16'h0407);
    drive(2'b00, 2'b10, 2'b10);
    chk("R11 close wins", rx_done_pages, 1);
    drive(2'b00, 2'b11, 2'b11);
    chk("R11 idle strobes", {tx_done, rx_done}, 0);
    drive(2'b10, 2'b00, 2'b00);
    chk("R11 idle step no effect", rx_addr, 16'h0504);
    drive(2'b00, 2'b00, 2'b10);

    // R10 inconsistent pointer sets and the unused select code
    cfg_write(2'd1, 8'h02);
    chk("R10 tx low not below boundary", cfg_err, 1);
    cfg_write(2'd3, 8'h04);
    chk("R9 select 3 no target", cfg_err, 1);
    cfg_write(2'd1, 8'h04);
    chk("R10 restored", cfg_err, 0);
    cfg_write(2'd2, 8'h03);
    chk("R10 rx high below boundary", cfg_err, 1);
    cfg_write(2'd2, 8'h05);

    // R9 write and start in the same cycle
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h01;
    drive(2'b01, 2'b00, 2'b00);
    cfg_we = 1'b0;
    chk("R9 start with write", tx_addr, 16'h0104);
    drive(2'b00, 2'b00, 2'b01);

    // random traffic against the model
    for (int i = 0; i < 20000; i++) begin
      cfg_we    = ($urandom % 150) == 0;
      cfg_sel   = 2'($urandom);
      cfg_wdata = 8'($urandom);
      st = {($urandom % 40) == 0, ($urandom % 40) == 0};
      ad = {($urandom % 3) != 0, ($urandom % 3) != 0};
      en = {($urandom % 400) == 0, ($urandom % 400) == 0};
      tick();
    end
    st = 2'b00; ad = 2'b00; en = 2'b00; cfg_we = 1'b0;
    tick();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule